// File: doc/BRIEF.md
# EDO DRAM Controller with Periodic Refresh

This block connects a single-word synchronous request port to an asynchronous extended-data-out DRAM holding 4M words of 4 bits. A request carries a read/write flag, a 22-bit word address and a 4-bit write word, and it is taken on a valid/ready handshake. The controller breaks the address into an 11-bit row and an 11-bit column, puts them on a shared 11-bit multiplexed address bus, and drives the active-low row strobe, column strobe, write enable and output enable. Every interval is a clock-cycle count, rounded up from a nanosecond parameter and a clock-period parameter. Read data comes back on a one-cycle response pulse.

A row stays open after an access. A later request to the same row toggles only the column strobe (page hit). A request to another row first closes the open row and waits out the row precharge time. A refresh timer raises a request at a rate that covers all 2048 rows within the refresh period parameter. At the next access boundary the refresh wins over any waiting request: the open row is closed, and a refresh cycle runs with the column strobe falling first. A parameter selects a row-only refresh instead, which drives rows from an internal counter. The data pins are split into an input, an output and an output enable, so the pad tristate sits outside the block.

Top module: `edo_dram_ctrl`

## Requirements
- R1: Row and column come from the request address, with row = addr[21:11] and column = addr[10:0]. The row is on the address bus when the row strobe falls and the column is on the bus when the column strobe falls.
- R2: On a write, write enable is low for at least one cycle before the column strobe falls, output enable stays high, and the write word is driven with its output enable asserted while the column strobe is low.
- R3: On a read, write enable is high and output enable is low when the column strobe falls. Exactly one response pulse returns the word most recently written to that address, or 0 if the address was never written.
- R4: Read data is captured no earlier than the row access time after the row strobe falls and no earlier than the column access time after the column strobe falls.
- R5: The row strobe stays low at least the random cycle time minus the precharge time and stays high at least the precharge time. Successive row-strobe falls are at least the random cycle time apart.
- R6: A request to the open row is served without a new row-strobe fall, and successive column-strobe falls within a row are at least the page cycle time apart.
- R7: A request to a row other than the open row raises the row strobe for precharge and then opens the new row, which is one row-strobe fall per such access.
- R8: In the default mode, each refresh drops the column strobe while the row strobe is high and then drops the row strobe. Successive refreshes are no further apart than the refresh interval plus one access.
- R9: While a column-first refresh is in progress, request ready is low.
- R10: In row-only refresh mode the column strobe stays high, and each refresh drives row addresses 0, 1, 2 and so on, wrapping at 2048.
- R11: During reset all four strobes are high, data output enable and response valid are low, and ready is high in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in upper 11 bits |
| req_wdata | input | 4 | Write word |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 4 | Read word |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_o | output | 4 | Write data to pads |
| dram_dq_oe | output | 1 | Pad drive enable |
| dram_dq_i | input | 4 | Data from pads |

## Verification
Writes to rows that are spread out and read back in reverse order test miss handling and the address split. A read of an untouched word tests the zero default. A burst of writes and reads within one row, started just after a refresh, separates page hits from needless reopening. Reads that alternate between two rows show that every miss precharges. A long run of back-to-back mixed traffic makes refreshes collide with pending requests. A long idle stretch checks the refresh rate in both refresh modes. The memory model returns inverted data until both access times have passed, so a capture that comes too early shows up as wrong data.

// File: rtl/edo_pkg.sv
`timescale 1ns/1ps
package edo_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,  // waiting; row may be open
    ST_ROW,   // row strobe low, row address on bus
    ST_WSET,  // write enable set up before column strobe
    ST_COL,   // column strobe low
    ST_HOLD,  // open row kept until minimum strobe-low time
    ST_PRE,   // row precharge
    ST_RCAS,  // refresh: column strobe first
    ST_RRAS,  // refresh: row strobe low
    ST_RPRE   // refresh precharge
  } ctl_state_e;

  function automatic int cyc_ceil(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

endpackage

// File: rtl/edo_sat_cnt.sv
`timescale 1ns/1ps
module edo_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (!(&q)) q <= q + 1'b1;
  end
endmodule

// File: rtl/edo_ref_timer.sv
`timescale 1ns/1ps
module edo_ref_timer #(
  parameter int IVL   = 1562,
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             done,
  output logic             pend,
  output logic [ROW_W-1:0] row
);
  localparam int TW = $clog2(IVL + 1);
  localparam logic [TW-1:0] LAST = TW'(IVL - 1);

  logic [TW-1:0] tick_q;
  logic          tick;

  assign tick = (tick_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= '0;
      pend   <= 1'b0;
      row    <= '0;
    end else begin
      tick_q <= tick ? '0 : tick_q + 1'b1;
      pend   <= tick | (pend & ~take);
      if (done) row <= row + 1'b1;
    end
  end

  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && !take) |=> pend);
endmodule

// File: rtl/edo_dram_ctrl.sv
`timescale 1ns/1ps
module edo_dram_ctrl
  import edo_pkg::*;
#(
  parameter int CLK_NS        = 10,
  parameter int MUX_W         = 11,
  parameter int DATA_W        = 4,
  parameter int T_RAC_NS      = 60,
  parameter int T_CAC_NS      = 15,
  parameter int T_RC_NS       = 104,
  parameter int T_PC_NS       = 25,
  parameter int T_RP_NS       = 40,
  parameter int T_RCD_NS      = 20,
  parameter int REF_PERIOD_NS = 32_000_000,
  parameter int REF_MODE      = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_we,
  input  logic [2*MUX_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                dram_ras_n,
  output logic                dram_cas_n,
  output logic                dram_we_n,
  output logic                dram_oe_n,
  output logic [MUX_W-1:0]    dram_addr,
  output logic [DATA_W-1:0]   dram_dq_o,
  output logic                dram_dq_oe,
  input  logic [DATA_W-1:0]   dram_dq_i
);
  localparam int  ADDR_W   = 2 * MUX_W;
  localparam int  NROWS    = 1 << MUX_W;
  localparam int  CW       = 8;
  localparam int  RAC_CY   = cyc_ceil(T_RAC_NS, CLK_NS);
  localparam int  CAC_CY   = cyc_ceil(T_CAC_NS, CLK_NS);
  localparam int  RC_CY    = cyc_ceil(T_RC_NS, CLK_NS);
  localparam int  PC_CY    = cyc_ceil(T_PC_NS, CLK_NS);
  localparam int  RP_CY    = cyc_ceil(T_RP_NS, CLK_NS);
  localparam int  RCD_CY   = cyc_ceil(T_RCD_NS, CLK_NS);
  localparam int  RAS_CY   = (RC_CY - RP_CY > RAC_CY + 1) ? RC_CY - RP_CY : RAC_CY + 1;
  localparam int  COL_CY   = (CAC_CY > PC_CY - 1) ? ((CAC_CY > 1) ? CAC_CY : 1)
                                                  : ((PC_CY - 1 > 1) ? PC_CY - 1 : 1);
  localparam int  REF_IVL  = REF_PERIOD_NS / (NROWS * CLK_NS);
  localparam bit  RAS_ONLY = (REF_MODE != 0);

  localparam logic [CW-1:0] RCD_LIM = CW'((RCD_CY > 1) ? RCD_CY - 1 : 0);
  localparam logic [CW-1:0] RP_LIM  = CW'(RP_CY - 1);
  localparam logic [CW-1:0] RAS_LIM = CW'(RAS_CY - 1);
  localparam logic [CW-1:0] RAC_LIM = CW'(RAC_CY);
  localparam logic [CW-1:0] COL_LIM = CW'(COL_CY);

  ctl_state_e state_q, state_d;
  logic              ref_q, ref_d, open_q, open_d, we_q, we_d;
  logic [MUX_W-1:0]  row_q, row_d, col_q, col_d, addr_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic [CW-1:0]     cnt_q, age_q;
  logic              ref_pend, ref_take, ref_done, accept;
  logic [MUX_W-1:0]  ref_row;
  logic              ras_act, cas_act, we_act, oe_act, ras_fall;
  logic [MUX_W-1:0]  req_row, req_col;

  assign req_row   = req_addr[ADDR_W-1:MUX_W];
  assign req_col   = req_addr[MUX_W-1:0];
  assign req_ready = (state_q == ST_IDLE) && !ref_pend;
  assign accept    = req_valid && req_ready;

  edo_ref_timer #(.IVL(REF_IVL), .ROW_W(MUX_W)) u_ref (
    .clk(clk), .rst(rst), .take(ref_take), .done(ref_done),
    .pend(ref_pend), .row(ref_row)
  );

  // cycles spent in the current state
  edo_sat_cnt #(.W(CW)) u_state_cnt (
    .clk(clk), .rst(rst), .clr(state_d != state_q), .q(cnt_q)
  );

  // cycles since the row strobe last fell
  edo_sat_cnt #(.W(CW)) u_ras_age (
    .clk(clk), .rst(rst), .clr(ras_fall), .q(age_q)
  );

  always_comb begin
    state_d  = state_q;
    ref_d    = ref_q;
    we_d     = we_q;
    row_d    = row_q;
    col_d    = col_q;
    wd_d     = wd_q;
    ref_take = 1'b0;
    ref_done = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_pend) begin
          ref_take = 1'b1;
          ref_d    = 1'b1;
          if (open_q)        state_d = ST_HOLD;
          else if (RAS_ONLY) state_d = ST_RRAS;
          else               state_d = ST_RCAS;
        end else if (accept) begin
          we_d  = req_we;
          row_d = req_row;
          col_d = req_col;
          wd_d  = req_wdata;
          if (open_q && req_row == row_q) state_d = req_we ? ST_WSET : ST_COL;
          else if (open_q)                state_d = ST_HOLD;
          else                            state_d = ST_ROW;
        end
      end
      ST_ROW:  if (cnt_q >= RCD_LIM) state_d = we_q ? ST_WSET : ST_COL;
      ST_WSET: state_d = ST_COL;
      ST_COL:  if (cnt_q >= COL_LIM && (we_q || age_q >= RAC_LIM)) state_d = ST_IDLE;
      ST_HOLD: if (age_q >= RAS_LIM) state_d = ST_PRE;
      ST_PRE: begin
        if (cnt_q >= RP_LIM) begin
          if (!ref_q)        state_d = ST_ROW;
          else if (RAS_ONLY) state_d = ST_RRAS;
          else               state_d = ST_RCAS;
        end
      end
      ST_RCAS: state_d = ST_RRAS;
      ST_RRAS: if (age_q >= RAS_LIM) state_d = ST_RPRE;
      ST_RPRE: begin
        if (cnt_q >= RP_LIM) begin
          state_d  = ST_IDLE;
          ref_d    = 1'b0;
          ref_done = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    open_d = open_q;
    if (state_d == ST_ROW) open_d = 1'b1;
    else if (state_d inside {ST_PRE, ST_RCAS, ST_RRAS}) open_d = 1'b0;

    ras_act = (state_d inside {ST_ROW, ST_WSET, ST_COL, ST_HOLD, ST_RRAS}) ||
              (state_d == ST_IDLE && open_d);
    cas_act = (state_d == ST_COL) || (state_d == ST_RCAS) ||
              (state_d == ST_RRAS && !RAS_ONLY);
    we_act  = (state_d == ST_WSET || state_d == ST_COL) && we_d;
    oe_act  = (state_d == ST_COL) && !we_d;

    unique case (state_d)
      ST_ROW:          addr_d = row_d;
      ST_WSET, ST_COL: addr_d = col_d;
      ST_RRAS:         addr_d = RAS_ONLY ? ref_row : dram_addr;
      default:         addr_d = dram_addr;
    endcase
  end

  assign ras_fall = ras_act && dram_ras_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      ref_q      <= 1'b0;
      open_q     <= 1'b0;
      we_q       <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
      wd_q       <= '0;
      dram_ras_n <= 1'b1;
      dram_cas_n <= 1'b1;
      dram_we_n  <= 1'b1;
      dram_oe_n  <= 1'b1;
      dram_addr  <= '0;
      dram_dq_o  <= '0;
      dram_dq_oe <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      state_q    <= state_d;
      ref_q      <= ref_d;
      open_q     <= open_d;
      we_q       <= we_d;
      row_q      <= row_d;
      col_q      <= col_d;
      wd_q       <= wd_d;
      dram_ras_n <= !ras_act;
      dram_cas_n <= !cas_act;
      dram_we_n  <= !we_act;
      dram_oe_n  <= !oe_act;
      dram_addr  <= addr_d;
      dram_dq_o  <= wd_d;
      dram_dq_oe <= we_act;
      rsp_valid  <= (state_q == ST_COL) && (state_d == ST_IDLE) && !we_q;
      if ((state_q == ST_COL) && (state_d == ST_IDLE) && !we_q) rsp_rdata <= dram_dq_i;
    end
  end

  // R2
  early_write_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n));

  // R2
  drive_only_write_chk: assert property (@(posedge clk) disable iff (rst)
    dram_dq_oe |-> (!dram_we_n && dram_oe_n));

  // R3
  read_oe_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_cas_n) && !dram_ras_n && dram_we_n) |-> !dram_oe_n);

  // R5
  ras_precharge_chk: assert property (@(posedge clk) disable iff (rst)
    ((RP_CY > 1) && $rose(dram_ras_n)) |=> dram_ras_n);

  // R8
  cas_first_chk: assert property (@(posedge clk) disable iff (rst)
    (!RAS_ONLY && $fell(dram_ras_n) && !dram_cas_n) |-> $past(!dram_cas_n));

  // R10
  row_only_cas_chk: assert property (@(posedge clk) disable iff (rst)
    (RAS_ONLY && !dram_ras_n && !dram_cas_n) |-> !dram_oe_n || !dram_we_n);

  // R9
  refresh_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (dram_ras_n && !dram_cas_n) |-> !req_ready);
endmodule

// File: tb/edo_dram_model.sv
`timescale 1ns/1ps
module edo_dram_model #(
  parameter int MUX_W   = 11,
  parameter int DW      = 4,
  parameter int RAC_NS  = 60,
  parameter int CAC_NS  = 15,
  parameter int HALF_NS = 5
) (
  input  logic             clk,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [MUX_W-1:0] addr,
  input  logic [DW-1:0]    dq_o,
  output logic [DW-1:0]    dq_i
);
  logic [DW-1:0]    mem [int];
  logic [MUX_W-1:0] row_l, col_l;
  longint           t_rf, t_cf, now;
  bit               rd_on;
  logic             p_ras, p_cas;
  int               key;
  logic [DW-1:0]    v;

  initial begin
    dq_i  = '0; row_l = '0; col_l = '0;
    t_rf  = 0;  t_cf  = 0;  rd_on = 0;
    p_ras = 1'b1; p_cas = 1'b1;
  end

  always @(negedge clk) begin
    now = longint'($time);
    if (p_ras && !ras_n && cas_n) begin
      row_l = addr;
      t_rf  = now - HALF_NS;
    end
    if (p_cas && !cas_n && !ras_n) begin
      col_l = addr;
      t_cf  = now - HALF_NS;
      key   = int'({row_l, col_l});
      if (!we_n) begin
        mem[key] = dq_o;
        rd_on    = 0;
      end else begin
        rd_on = 1;
      end
    end
    if (cas_n) rd_on = 0;
    key = int'({row_l, col_l});
    v   = mem.exists(key) ? mem[key] : '0;
    if (rd_on && !oe_n && (now + HALF_NS - t_rf >= RAC_NS) &&
        (now + HALF_NS - t_cf >= CAC_NS))
      dq_i = v;
    else
      dq_i = ~v;
    p_ras = ras_n;
    p_cas = cas_n;
  end
endmodule

// File: tb/edo_dram_ctrl_tb.sv
`timescale 1ns/1ps
module edo_dram_ctrl_tb;
  localparam int REF_PERIOD = 6_144_000;
  localparam int IVL        = 300;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [3:0]  rsp_rdata;
  logic        ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [10:0] dadr;
  logic [3:0]  dq_o, dq_i;

  logic        ro_ready, ro_rsp_valid, ro_ras_n, ro_cas_n, ro_we_n, ro_oe_n, ro_dq_oe;
  logic [3:0]  ro_rdata, ro_dq_o, ro_dq_i;
  logic [10:0] ro_addr;

  always #5 clk = ~clk;

  edo_dram_ctrl #(.REF_PERIOD_NS(REF_PERIOD), .REF_MODE(0)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_addr(dadr), .dram_dq_o(dq_o), .dram_dq_oe(dq_oe), .dram_dq_i(dq_i)
  );

  edo_dram_model u_mem (
    .clk(clk), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(dadr), .dq_o(dq_o), .dq_i(dq_i)
  );

  edo_dram_ctrl #(.REF_PERIOD_NS(REF_PERIOD), .REF_MODE(1)) u_dut_ro (
    .clk(clk), .rst(rst), .req_valid(1'b0), .req_ready(ro_ready),
    .req_we(1'b0), .req_addr(22'd0), .req_wdata(4'd0),
    .rsp_valid(ro_rsp_valid), .rsp_rdata(ro_rdata),
    .dram_ras_n(ro_ras_n), .dram_cas_n(ro_cas_n), .dram_we_n(ro_we_n), .dram_oe_n(ro_oe_n),
    .dram_addr(ro_addr), .dram_dq_o(ro_dq_o), .dram_dq_oe(ro_dq_oe), .dram_dq_i(ro_dq_i)
  );

  edo_dram_model u_mem_ro (
    .clk(clk), .ras_n(ro_ras_n), .cas_n(ro_cas_n), .we_n(ro_we_n), .oe_n(ro_oe_n),
    .addr(ro_addr), .dq_o(ro_dq_o), .dq_i(ro_dq_i)
  );

  int checks = 0, errs = 0, cyc = 0;
  int t_rf = -1000, t_rr = -1000, t_cf = -1000, last_ref = -1;
  int ras_falls = 0, cbr_cnt = 0, ror_cnt = 0, ror_exp = 0;
  bit in_ref = 0, ras_since_cas = 1;
  logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, p_ro_ras = 1'b1;
  logic [10:0] cur_row = '0, cur_col = '0;
  logic [3:0]  cur_data = '0;
  logic [3:0]  shadow [int];
  logic [3:0]  exp_q [$];
  logic [3:0]  e;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  endtask

  // pin monitor and reference checks, once per clock away from the edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (p_ras && !ras_n) begin
        chk((cyc - t_rr) * 10 >= 40, "R5 precharge ns", (cyc - t_rr) * 10, 40);
        if (t_rf > 0) chk((cyc - t_rf) * 10 >= 104, "R5 cycle ns", (cyc - t_rf) * 10, 104);
        t_rf = cyc;
        ras_since_cas = 1;
        if (cas_n) begin
          ras_falls++;
          chk(dadr == cur_row, "R1 row", dadr, cur_row);
        end else begin
          chk(!p_cas, "R8 column first", p_cas, 0);
        end
      end
      if (!p_ras && ras_n) begin
        chk((cyc - t_rf) * 10 >= 64, "R5 low ns", (cyc - t_rf) * 10, 64);
        t_rr = cyc;
        in_ref = 0;
      end
      if (p_cas && !cas_n && ras_n) begin
        in_ref = 1;
        cbr_cnt++;
        if (last_ref >= 0)
          chk(cyc - last_ref <= IVL + 40, "R8 refresh gap", cyc - last_ref, IVL + 40);
        last_ref = cyc;
      end
      if (p_cas && !cas_n && !ras_n) begin
        chk(dadr == cur_col, "R1 column", dadr, cur_col);
        if (!ras_since_cas)
          chk((cyc - t_cf) * 10 >= 25, "R6 page spacing ns", (cyc - t_cf) * 10, 25);
        t_cf = cyc;
        ras_since_cas = 0;
        if (!we_n) begin
          chk(!p_we, "R2 early write", p_we, 0);
          chk(oe_n, "R2 oe high", oe_n, 1);
          chk(dq_oe && dq_o == cur_data, "R2 write data", dq_o, cur_data);
        end else begin
          chk(!oe_n, "R3 oe low", oe_n, 0);
        end
      end
      if (in_ref) chk(!req_ready, "R9 ready during refresh", req_ready, 0);
      if (rsp_valid) begin
        if (exp_q.size() > 0) begin
          e = exp_q.pop_front();
          chk(rsp_rdata == e, "R3 R4 read data", rsp_rdata, e);
        end else begin
          chk(0, "R3 spurious response", 1, 0);
        end
      end
      if (p_ro_ras && !ro_ras_n) begin
        chk(ro_cas_n, "R10 column high", ro_cas_n, 1);
        chk(ro_addr == 11'(ror_exp), "R10 refresh row", ro_addr, ror_exp);
        ror_exp = (ror_exp + 1) % 2048;
        ror_cnt++;
      end
      if (!ro_ras_n) chk(ro_cas_n, "R10 column stays high", ro_cas_n, 1);
    end
    p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_ro_ras = ro_ras_n;
  end

  task automatic issue(input bit we, input logic [21:0] a, input logic [3:0] d);
    req_we = we; req_addr = a; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    cur_row = a[21:11]; cur_col = a[10:0]; cur_data = d;
    if (we) shadow[int'(a)] = d;
    else exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 4'd0);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 200 && exp_q.size() > 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic after_refresh();
    int c;
    c = cbr_cnt;
    while (cbr_cnt == c) @(negedge clk);
    while (in_ref || !req_ready) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int rf0, c0;
    logic [21:0] a;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(ras_n && cas_n && we_n && oe_n, "R11 strobes", {ras_n, cas_n, we_n, oe_n}, 15);
    chk(!dq_oe && !rsp_valid, "R11 drive/resp", {dq_oe, rsp_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready, "R11 ready", req_ready, 1);

    // spread rows: writes then reverse reads (R1 R3 R7)
    for (int i = 0; i < 6; i++) begin
      a = {11'((i * 37 + 5) % 2048), 11'((i * 101 + 3) % 2048)};
      issue(1, a, 4'(i + 3));
    end
    for (int i = 5; i >= 0; i--) begin
      a = {11'((i * 37 + 5) % 2048), 11'((i * 101 + 3) % 2048)};
      issue(0, a, 4'd0);
    end
    issue(0, {11'd2000, 11'd1999}, 4'd0);  // R3 unwritten reads 0
    drain();

    // page burst within one row (R6)
    after_refresh();
    rf0 = ras_falls;
    for (int i = 1; i <= 4; i++) issue(1, {11'h155, 11'(i)}, 4'(9 + i));
    for (int i = 1; i <= 4; i++) issue(0, {11'h155, 11'(i)}, 4'd0);
    drain();
    chk(ras_falls == rf0 + 1, "R6 single open", ras_falls - rf0, 1);

    // alternating rows: each access reopens (R7)
    after_refresh();
    rf0 = ras_falls;
    for (int i = 0; i < 6; i++) issue(0, {((i % 2) != 0) ? 11'h20 : 11'h10, 11'd7}, 4'd0);
    drain();
    chk(ras_falls == rf0 + 6, "R7 reopen count", ras_falls - rf0, 6);

    // back-to-back mixed traffic across refreshes (R9)
    for (int i = 0; i < 60; i++) begin
      a = {11'((i / 4) * 3), 11'((i * 13) % 2048)};
      issue((i % 3) != 2, a, 4'(i * 7));
    end
    drain();

    // idle: refresh rate in both modes (R8 R10)
    c0 = cbr_cnt;
    rf0 = ror_cnt;
    repeat (1500) @(negedge clk);
    chk(cbr_cnt - c0 >= 4, "R8 refresh count", cbr_cnt - c0, 4);
    chk(ror_cnt - rf0 >= 4, "R10 refresh count", ror_cnt - rf0, 4);
    chk(exp_q.size() == 0, "R3 all responses", exp_q.size(), 0);
    finish_run();
  end
endmodule